// File: doc/BRIEF.md
# Double-Buffered Frame Store with Gated Swap

This block holds two equal image buffers for a small image-filter pipeline. At any moment one buffer is the visible image, read by the display scanner. The other is the hidden buffer, the only one a filter engine may write. The engine reads its source pixels from the visible buffer. Each filter pass therefore works on what is on screen, and repeated passes build on one another.

Two single-cycle user commands drive the block. One launches a filter pass. The other asks for the roles of the two buffers to be exchanged. The exchange is held back until the next frame-start marker, so a frame is never shown half from one buffer and half from the other. Both commands are refused while a pass is running. A single select bit records which buffer is visible. Every read port is registered and has one cycle of latency.

Top module: `frame_swap_ctrl`

## Requirements
- R1: During and after reset, `front_sel` is 0 (bank 0 is visible), `busy` is 0 and `eng_start` is 0.
- R2: A `start_req` pulse while `busy` is 0 makes `eng_start` high for exactly one cycle, in the next cycle. `busy` rises in that same cycle and falls in the cycle after `eng_done` is sampled high.
- R3: A `start_req` that arrives while `busy` is 1 is discarded and produces no `eng_start`.
- R4: A `swap_req` pulse while idle is held pending. `front_sel` toggles in the cycle after the next `frame_start`, and stays unchanged before that.
- R5: A `swap_req` that arrives while `busy` is 1 is discarded. No later `frame_start` toggles `front_sel` because of it.
- R6: A swap that is already pending survives a pass. A `frame_start` seen while `busy` is 1 leaves `front_sel` alone, and the first `frame_start` with `busy` at 0 toggles it.
- R7: Several `swap_req` pulses before one frame boundary give a single toggle. A `swap_req` in the same cycle as the toggling `frame_start` is absorbed and does not re-arm the swap.
- R8: `disp_rd_data` and `eng_rd_data` return, one cycle after the address, the word of the bank that was visible (bank `front_sel`) when the address was presented.
- R9: `eng_wr_en` writes `eng_wr_data` only into the hidden bank (bank `!front_sel`). The visible image never changes because of an engine write.
- R10: A display read and an engine write in the same cycle both take effect.
- R11: A pass followed by a swap shows the processed image. A second pass then reads that processed image, so the effect compounds.
- R12: When `frame_start` with a swap pending and an idle `start_req` fall in the same cycle, both are taken. The new pass reads the newly visible bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Debounced one-cycle request to run a filter pass |
| swap_req | input | 1 | Debounced one-cycle request to exchange buffers |
| frame_start | input | 1 | One-cycle marker at the start of each display frame |
| eng_start | output | 1 | One-cycle launch pulse to the filter engine |
| eng_done | input | 1 | Filter engine finished its pass |
| eng_rd_addr | input | AW | Engine source read address (visible bank) |
| eng_rd_data | output | PIX_W | Engine source pixel, one cycle after address |
| eng_wr_en | input | 1 | Engine write strobe (hidden bank) |
| eng_wr_addr | input | AW | Engine write address |
| eng_wr_data | input | PIX_W | Engine write pixel |
| disp_rd_addr | input | AW | Display read address (visible bank) |
| disp_rd_data | output | PIX_W | Display pixel, one cycle after address |
| busy | output | 1 | A filter pass is in progress |
| front_sel | output | 1 | Index of the visible bank |

## Verification
The collisions that matter are between the buffer exchange and the launch of a pass. The bench provokes the case where a frame boundary with a swap pending lands in the very cycle an idle start request arrives. There it expects both actions: the select bit toggles, the launch pulse appears, and the engine's first read returns the word of the bank that has just become visible. It also lands a swap request on the same edge as the frame boundary that consumes the earlier request. There it expects exactly one toggle, judged by a further frame boundary that must leave the select bit alone.

// File: rtl/frame_swap_ctrl.sv
module frame_swap_ctrl #(
  parameter int PIX_W = 8,
  parameter int IMG_W = 40,
  parameter int IMG_H = 30,
  localparam int DEPTH = IMG_W * IMG_H,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             swap_req,
  input  logic             frame_start,
  output logic             eng_start,
  input  logic             eng_done,
  input  logic [AW-1:0]    eng_rd_addr,
  output logic [PIX_W-1:0] eng_rd_data,
  input  logic             eng_wr_en,
  input  logic [AW-1:0]    eng_wr_addr,
  input  logic [PIX_W-1:0] eng_wr_data,
  input  logic [AW-1:0]    disp_rd_addr,
  output logic [PIX_W-1:0] disp_rd_data,
  output logic             busy,
  output logic             front_sel
);

  logic pend, sel_q, take_swap, take_start;
  logic [PIX_W-1:0] bank0 [DEPTH];
  logic [PIX_W-1:0] bank1 [DEPTH];
  logic [PIX_W-1:0] qa0, qa1, qb0, qb1;
  logic [AW-1:0] ab0, ab1;
  logic we0, we1;

  assign take_swap  = frame_start & pend & ~busy;
  assign take_start = start_req & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      front_sel <= 1'b0;
      busy      <= 1'b0;
      pend      <= 1'b0;
      eng_start <= 1'b0;
    end else begin
      eng_start <= take_start;
      if (take_start)    busy <= 1'b1;
      else if (eng_done) busy <= 1'b0;
      if (take_swap) begin
        front_sel <= ~front_sel;
        pend      <= 1'b0;
      end else if (swap_req & ~busy) begin
        pend <= 1'b1;
      end
    end
  end

  // port B of each bank: engine read when visible, engine write when hidden
  assign ab0 = front_sel ? eng_wr_addr : eng_rd_addr;
  assign ab1 = front_sel ? eng_rd_addr : eng_wr_addr;
  assign we0 = eng_wr_en &  front_sel;
  assign we1 = eng_wr_en & ~front_sel;

  always_ff @(posedge clk) begin
    if (we0) bank0[ab0] <= eng_wr_data;
    if (we1) bank1[ab1] <= eng_wr_data;
    qa0   <= bank0[disp_rd_addr];
    qa1   <= bank1[disp_rd_addr];
    qb0   <= bank0[ab0];
    qb1   <= bank1[ab1];
    sel_q <= front_sel;
  end

  assign disp_rd_data = sel_q ? qa1 : qa0;
  assign eng_rd_data  = sel_q ? qb1 : qb0;

endmodule

// File: rtl/frame_swap_ctrl_chk.sv
module frame_swap_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic start_req,
  input logic frame_start,
  input logic eng_start,
  input logic eng_done,
  input logic busy,
  input logic front_sel
);

  assert_start_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(start_req && !busy));

  assert_start_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_busy_with_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy);

  assert_busy_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(eng_done));

  assert_swap_on_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (front_sel != $past(front_sel)) |-> $past(frame_start));

  assert_no_swap_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(front_sel));

endmodule

bind frame_swap_ctrl frame_swap_ctrl_chk u_chk (.*);

// File: tb/tb_frame_swap_ctrl.sv
module tb_frame_swap_ctrl;
  localparam int PW = 8;
  localparam int W = 40;
  localparam int H = 30;
  localparam int N = W * H;
  localparam int AW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_req = 1'b0, swap_req = 1'b0, frame_start = 1'b0, eng_done = 1'b0;
  logic eng_start, busy, front_sel;
  logic [AW-1:0] eng_rd_addr = '0, eng_wr_addr = '0, disp_rd_addr = '0;
  logic eng_wr_en = 1'b0;
  logic [PW-1:0] eng_wr_data = '0;
  logic [PW-1:0] eng_rd_data, disp_rd_data;

  logic [PW-1:0] img [2][N];
  int mf = 0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  frame_swap_ctrl #(.PIX_W(PW), .IMG_W(W), .IMG_H(H)) dut (.*);

  function automatic logic [PW-1:0] filt(logic [PW-1:0] v);
    return v - (v >> 2);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_swap();
    @(negedge clk) swap_req = 1'b1;
    @(negedge clk) swap_req = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  task automatic finish_pass();
    @(negedge clk) eng_done = 1'b1;
    @(negedge clk) eng_done = 1'b0;
  endtask

  task automatic load_back(input int seed);
    for (int a = 0; a < N; a++) begin
      @(negedge clk);
      eng_wr_en = 1'b1;
      eng_wr_addr = AW'(a);
      eng_wr_data = PW'(a * 7 + seed);
      img[1-mf][a] = PW'(a * 7 + seed);
    end
    @(negedge clk) eng_wr_en = 1'b0;
  endtask

  task automatic verify_front(input string req);
    int bad = 0, first_a = 0, first_e = 0;
    for (int a = 0; a < N; a++) begin
      @(negedge clk) disp_rd_addr = AW'(a);
      @(negedge clk);
      if (disp_rd_data !== img[mf][a]) begin
        if (bad == 0) begin first_a = int'(disp_rd_data); first_e = int'(img[mf][a]); end
        bad++;
      end
    end
    chk(bad == 0, req, first_a, first_e);
  endtask

  task automatic t_reset();
    chk(front_sel == 1'b0, "R1 front_sel", int'(front_sel), 0);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(eng_start == 1'b0, "R1 eng_start", int'(eng_start), 0);
  endtask

  task automatic t_setup();
    load_back(3);
    pulse_swap();
    tick(4);
    chk(front_sel == 1'b0, "R4 no toggle before frame", int'(front_sel), 0);
    pulse_frame();
    mf = 1;
    chk(front_sel == 1'b1, "R4 toggle after frame", int'(front_sel), 1);
    load_back(101);
    verify_front("R9 front intact after hidden load");
  endtask

  // full pass: engine reads visible, writes hidden, display reads alongside
  task automatic t_pass(input string req);
    int bad_e = 0, bad_d = 0;
    logic [PW-1:0] v;
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    chk(eng_start == 1'b1 && busy == 1'b1, "R2 launch", int'({eng_start, busy}), 3);
    @(negedge clk);
    chk(eng_start == 1'b0, "R2 single pulse", int'(eng_start), 0);
    v = '0;
    for (int a = 0; a <= N; a++) begin
      @(negedge clk);
      eng_rd_addr = AW'(a % N);
      disp_rd_addr = AW'((a + 11) % N);
      eng_wr_en = (a > 0);
      eng_wr_addr = AW'((a + N - 1) % N);
      eng_wr_data = filt(v);
      if (a > 0) img[1-mf][a-1] = filt(img[mf][a-1]);
      @(negedge clk);
      eng_wr_en = 1'b0;
      v = eng_rd_data;
      if (eng_rd_data !== img[mf][a % N]) bad_e++;
      if (disp_rd_data !== img[mf][(a + 11) % N]) bad_d++;
    end
    chk(bad_e == 0, "R8 engine reads visible bank", bad_e, 0);
    chk(bad_d == 0, "R10 display read beside write", bad_d, 0);
    chk(busy == 1'b1, "R2 busy during pass", int'(busy), 1);
    finish_pass();
    chk(busy == 1'b0, "R2 busy falls after done", int'(busy), 0);
    verify_front({req, " R9 visible untouched"});
  endtask

  task automatic t_compound();
    pulse_swap();
    pulse_frame();
    mf = 1 - mf;
    chk(front_sel == 1'(mf), "R11 swap after pass", int'(front_sel), mf);
    verify_front("R11 processed image shown");
    t_pass("R11 second pass");
    pulse_swap();
    pulse_frame();
    mf = 1 - mf;
    verify_front("R11 compounded image shown");
  endtask

  task automatic t_busy_ignore();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    tick(2);
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    chk(eng_start == 1'b0, "R3 start ignored while busy", int'(eng_start), 0);
    pulse_swap();
    pulse_frame();
    chk(front_sel == 1'(mf), "R5 no toggle while busy", int'(front_sel), mf);
    finish_pass();
    pulse_frame();
    chk(front_sel == 1'(mf), "R5 dropped request stays dropped", int'(front_sel), mf);
  endtask

  task automatic t_pending_across_busy();
    pulse_swap();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    pulse_frame();
    chk(front_sel == 1'(mf), "R6 held during pass", int'(front_sel), mf);
    finish_pass();
    pulse_frame();
    mf = 1 - mf;
    chk(front_sel == 1'(mf), "R6 taken after pass", int'(front_sel), mf);
  endtask

  task automatic t_merge();
    pulse_swap();
    pulse_swap();
    pulse_frame();
    mf = 1 - mf;
    chk(front_sel == 1'(mf), "R7 merged toggle", int'(front_sel), mf);
    pulse_frame();
    chk(front_sel == 1'(mf), "R7 only one toggle", int'(front_sel), mf);
    pulse_swap();
    @(negedge clk) begin frame_start = 1'b1; swap_req = 1'b1; end
    @(negedge clk) begin frame_start = 1'b0; swap_req = 1'b0; end
    mf = 1 - mf;
    chk(front_sel == 1'(mf), "R7 toggle with coincident request", int'(front_sel), mf);
    pulse_frame();
    chk(front_sel == 1'(mf), "R7 coincident request absorbed", int'(front_sel), mf);
  endtask

  task automatic t_collide();
    pulse_swap();
    @(negedge clk) begin frame_start = 1'b1; start_req = 1'b1; eng_rd_addr = AW'(5); end
    @(negedge clk) begin frame_start = 1'b0; start_req = 1'b0; end
    mf = 1 - mf;
    chk(front_sel == 1'(mf), "R12 swap taken", int'(front_sel), mf);
    chk(eng_start == 1'b1, "R12 pass launched", int'(eng_start), 1);
    @(negedge clk) eng_rd_addr = AW'(5);
    @(negedge clk);
    chk(eng_rd_data === img[mf][5], "R12 engine reads new front", int'(eng_rd_data), int'(img[mf][5]));
    finish_pass();
  endtask

  initial begin
    tick(3);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_setup();
    t_pass("R9 first pass");
    t_compound();
    t_busy_ignore();
    t_pending_across_busy();
    t_merge();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule